// File: doc/BRIEF.md
# SPI Command-Engine Control Register Block

This block is the software-facing front of a command-driven SPI controller. A host reaches it over a simple 32-bit register bus that has separate read and write strobes and an 8-bit byte address. Through that bus software pushes 16-bit instructions into the command queue and bytes into the transmit queue. It drains received bytes, either popping them or inspecting the head entry without removing it. It reads how much free space each outbound queue has and how many bytes the inbound queue holds. It holds the engine in reset, or releases it, through a reset register.

The interrupt logic has four causes. Three of them are level conditions: the command queue is nearly empty, the transmit queue is nearly empty, and the receive queue is nearly full. Each compares a status input against a threshold set by a parameter. The fourth is a sync event. When the engine runs a sync instruction, it reports an 8-bit identifier. The block keeps that identifier so software can tell which program has completed. Each cause has a pending bit and an enable bit, and the single interrupt line is high when any enabled cause is pending.

The queue ports use valid/ready handshakes. A push presents its data for exactly the one cycle of the bus write. If the queue's ready is low in that cycle, the word is dropped; the block gives no back-pressure to the bus and does not retry. On the receive side, the queue presents `rx_valid`/`rx_data`, and the block raises `rx_ready` for one cycle to take the head entry.

Top module: `spi_cmd_ctl_regs`

## Requirements
- R1: A read of byte address 0x00 returns the identification word, with bits 23:16 = 1, bits 15:8 = `VER_MINOR`, bits 7:0 = `VER_PATCH`, and bits 31:24 = 0.
- R2: After reset `engine_reset` is 1 and address 0x40 reads 1. A write to 0x40 stores bit 0 of the write data, and `engine_reset` follows it from the next cycle (0 releases the engine, 1 holds it).
- R3: Address 0x80 is the enable register. A write stores bits 3:0 of the write data, a read returns them in bits 3:0, and bits 31:4 read 0. It resets to 0.
- R4: Address 0x84 reads the pending bits in 3:0. Writing 1 to a bit clears it, and writing 0xFF clears all four. A cause that is active in the same cycle as the clear keeps its bit set.
- R5: Address 0x88 reads pending AND enable. `irq` is 1 exactly when that value is nonzero.
- R6: A cycle with `sync_valid` high stores `sync_id`, which is then read at 0xC0 in bits 7:0, and sets pending bit 3.
- R7: Reads of 0xD0, 0xD4 and 0xD8 return `cmd_room`, `tx_room` and `rx_level`, zero-extended.
- R8: A write to 0xE0 raises `cmd_push_valid` in that same cycle with `cmd_push_data` = write data bits 15:0. No other write raises it.
- R9: A write to 0xE4 raises `tx_push_valid` in that same cycle with `tx_push_data` = write data bits 7:0.
- R10: A read of 0xE8 while `rx_valid` is 1 returns `rx_data` and raises `rx_ready` for that one cycle. While `rx_valid` is 0, the same read returns 0 and `rx_ready` stays 0.
- R11: A read of 0xEC returns `rx_data` when `rx_valid` is 1 (0 otherwise) and never raises `rx_ready`.
- R12: `bus_rvalid` is 1 in the cycle after each `bus_ren` cycle, and `bus_rdata` then holds the value read.
- R13: Pending bit 0 is set on every cycle in which `cmd_room >= CMD_AE_ROOM`, bit 1 when `tx_room >= TX_AE_ROOM`, and bit 2 when `rx_level >= RX_AF_LEVEL`. A clear has no effect while its condition holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wen | input | 1 | Register write strobe |
| bus_ren | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_ren |
| cmd_push_valid | output | 1 | Command queue push request |
| cmd_push_ready | input | 1 | Command queue can accept |
| cmd_push_data | output | CMD_W (16) | Instruction word to push |
| tx_push_valid | output | 1 | Transmit queue push request |
| tx_push_ready | input | 1 | Transmit queue can accept |
| tx_push_data | output | DATA_W (8) | Byte to push |
| rx_valid | input | 1 | Receive queue is not empty |
| rx_ready | output | 1 | Pop the receive queue head |
| rx_data | input | DATA_W (8) | Receive queue head entry |
| cmd_room | input | LVL_W (6) | Free entries in the command queue |
| tx_room | input | LVL_W (6) | Free entries in the transmit queue |
| rx_level | input | LVL_W (6) | Filled entries in the receive queue |
| sync_valid | input | 1 | Engine has executed a sync instruction |
| sync_id | input | SYNC_W (8) | Identifier carried by that sync |
| engine_reset | output | 1 | Holds the engine in reset when 1 |
| irq | output | 1 | Interrupt request |

## Verification
A stuck or lost pending bit shows at the ports within two cycles of its cause. The interrupt line and a read of 0x84 or 0x88 disagree with the cause the bench applied, and a level cause that has been wrongly cleared appears as a bit that stays at 0 on the very next read. A wrong sync identifier register shows on the first read of 0xC0 after the pulse. A faulty decode on the queue side appears in the same cycle as the access: a push or pop strobe is missing or appears on the wrong address, or the receive queue is popped while it is empty. The reset-hold register and the enable register are checked by reading them back right after each write and by watching `engine_reset`.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned BUS_W  = 32;

  // register byte addresses
  localparam logic [ADDR_W-1:0] A_IDENT    = 8'h00;
  localparam logic [ADDR_W-1:0] A_HOLD     = 8'h40;
  localparam logic [ADDR_W-1:0] A_IEN      = 8'h80;
  localparam logic [ADDR_W-1:0] A_IPEND    = 8'h84;
  localparam logic [ADDR_W-1:0] A_ISRC     = 8'h88;
  localparam logic [ADDR_W-1:0] A_SYNC     = 8'hC0;
  localparam logic [ADDR_W-1:0] A_CMD_ROOM = 8'hD0;
  localparam logic [ADDR_W-1:0] A_TX_ROOM  = 8'hD4;
  localparam logic [ADDR_W-1:0] A_RX_LVL   = 8'hD8;
  localparam logic [ADDR_W-1:0] A_CMD_PUSH = 8'hE0;
  localparam logic [ADDR_W-1:0] A_TX_PUSH  = 8'hE4;
  localparam logic [ADDR_W-1:0] A_RX_POP   = 8'hE8;
  localparam logic [ADDR_W-1:0] A_RX_PEEK  = 8'hEC;

  // interrupt cause bit positions
  localparam int unsigned IRQ_N       = 4;
  localparam int unsigned IRQ_CMD_LOW = 0;
  localparam int unsigned IRQ_TX_LOW  = 1;
  localparam int unsigned IRQ_RX_HIGH = 2;
  localparam int unsigned IRQ_SYNC    = 3;

  localparam logic [7:0] IDENT_MAJOR = 8'd1;
endpackage

// File: rtl/ctl_thresholds.sv
module ctl_thresholds #(
  parameter int unsigned LVL_W       = 6,
  parameter int unsigned CMD_AE_ROOM = 16,
  parameter int unsigned TX_AE_ROOM  = 16,
  parameter int unsigned RX_AF_LEVEL = 24
) (
  input  logic [LVL_W-1:0] cmd_room,
  input  logic [LVL_W-1:0] tx_room,
  input  logic [LVL_W-1:0] rx_level,
  output logic             cmd_low,
  output logic             tx_low,
  output logic             rx_high
);
  localparam logic [LVL_W-1:0] CMD_THR = LVL_W'(CMD_AE_ROOM);
  localparam logic [LVL_W-1:0] TX_THR  = LVL_W'(TX_AE_ROOM);
  localparam logic [LVL_W-1:0] RX_THR  = LVL_W'(RX_AF_LEVEL);

  always_comb begin
    cmd_low = (cmd_room >= CMD_THR);
    tx_low  = (tx_room  >= TX_THR);
    rx_high = (rx_level >= RX_THR);
  end
endmodule

// File: rtl/ctl_irq_unit.sv
module ctl_irq_unit #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cause,
  input  logic         en_wr,
  input  logic [N-1:0] en_wdata,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] pending,
  output logic [N-1:0] enable,
  output logic [N-1:0] source,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enable <= '0;
    else if (en_wr) enable <= en_wdata;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    logic kill;
    assign kill = clr_wr && clr_mask[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        pending[i] <= 1'b0;
      else if (cause[i]) pending[i] <= 1'b1;
      else if (kill)     pending[i] <= 1'b0;
    end

    assert_cause_sets_R13: assert property (@(posedge clk) disable iff (!rst_n)
      cause[i] |=> pending[i]);
    assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (kill && !cause[i]) |=> !pending[i]);
  end

  assign source = pending & enable;
  assign irq    = |source;
endmodule

// File: rtl/ctl_read_mux.sv
module ctl_read_mux import spi_ctl_pkg::*; #(
  parameter int unsigned LVL_W     = 6,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned SYNC_W    = 8,
  parameter logic [7:0]  VER_MINOR = 8'h02,
  parameter logic [7:0]  VER_PATCH = 8'h61
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              hold,
  input  logic [IRQ_N-1:0]  enable,
  input  logic [IRQ_N-1:0]  pending,
  input  logic [IRQ_N-1:0]  source,
  input  logic [SYNC_W-1:0] sync_last,
  input  logic [LVL_W-1:0]  cmd_room,
  input  logic [LVL_W-1:0]  tx_room,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic [BUS_W-1:0]  value
);
  logic [BUS_W-1:0] head;
  assign head = rx_valid ? BUS_W'(rx_data) : '0;

  always_comb begin
    case (addr)
      A_IDENT:    value = {8'h00, IDENT_MAJOR, VER_MINOR, VER_PATCH};
      A_HOLD:     value = BUS_W'(hold);
      A_IEN:      value = BUS_W'(enable);
      A_IPEND:    value = BUS_W'(pending);
      A_ISRC:     value = BUS_W'(source);
      A_SYNC:     value = BUS_W'(sync_last);
      A_CMD_ROOM: value = BUS_W'(cmd_room);
      A_TX_ROOM:  value = BUS_W'(tx_room);
      A_RX_LVL:   value = BUS_W'(rx_level);
      A_RX_POP:   value = head;
      A_RX_PEEK:  value = head;
      default:    value = '0;
    endcase
  end
endmodule

// File: rtl/spi_cmd_ctl_regs.sv
module spi_cmd_ctl_regs import spi_ctl_pkg::*; #(
  parameter int unsigned LVL_W       = 6,
  parameter int unsigned CMD_W       = 16,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_W      = 8,
  parameter int unsigned CMD_AE_ROOM = 16,
  parameter int unsigned TX_AE_ROOM  = 16,
  parameter int unsigned RX_AF_LEVEL = 24,
  parameter logic [7:0]  VER_MINOR   = 8'h02,
  parameter logic [7:0]  VER_PATCH   = 8'h61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_rvalid,
  output logic              cmd_push_valid,
  input  logic              cmd_push_ready,
  output logic [CMD_W-1:0]  cmd_push_data,
  output logic              tx_push_valid,
  input  logic              tx_push_ready,
  output logic [DATA_W-1:0] tx_push_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [LVL_W-1:0]  cmd_room,
  input  logic [LVL_W-1:0]  tx_room,
  input  logic [LVL_W-1:0]  rx_level,
  input  logic              sync_valid,
  input  logic [SYNC_W-1:0] sync_id,
  output logic              engine_reset,
  output logic              irq
);
  logic wr_hold, wr_ien, wr_iclr;
  logic cmd_low, tx_low, rx_high;
  logic [IRQ_N-1:0] cause, pending, enable, source;
  logic [SYNC_W-1:0] sync_last;
  logic [BUS_W-1:0] rd_value;
  logic wdata_unused;
  logic ready_unused;

  assign wdata_unused = ^bus_wdata[BUS_W-1:CMD_W];
  // a push with ready low is dropped; nothing here depends on ready
  assign ready_unused = cmd_push_ready ^ tx_push_ready;

  // write decode
  assign wr_hold = bus_wen && (bus_addr == A_HOLD);
  assign wr_ien  = bus_wen && (bus_addr == A_IEN);
  assign wr_iclr = bus_wen && (bus_addr == A_IPEND);

  // queue ports
  assign cmd_push_valid = bus_wen && (bus_addr == A_CMD_PUSH);
  assign cmd_push_data  = bus_wdata[CMD_W-1:0];
  assign tx_push_valid  = bus_wen && (bus_addr == A_TX_PUSH);
  assign tx_push_data   = bus_wdata[DATA_W-1:0];
  assign rx_ready       = bus_ren && (bus_addr == A_RX_POP) && rx_valid;

  ctl_thresholds #(
    .LVL_W(LVL_W), .CMD_AE_ROOM(CMD_AE_ROOM),
    .TX_AE_ROOM(TX_AE_ROOM), .RX_AF_LEVEL(RX_AF_LEVEL)
  ) u_thr (
    .cmd_room(cmd_room), .tx_room(tx_room), .rx_level(rx_level),
    .cmd_low(cmd_low), .tx_low(tx_low), .rx_high(rx_high)
  );

  always_comb begin
    cause = '0;
    cause[IRQ_CMD_LOW] = cmd_low;
    cause[IRQ_TX_LOW]  = tx_low;
    cause[IRQ_RX_HIGH] = rx_high;
    cause[IRQ_SYNC]    = sync_valid;
  end

  ctl_irq_unit #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .cause(cause),
    .en_wr(wr_ien), .en_wdata(bus_wdata[IRQ_N-1:0]),
    .clr_wr(wr_iclr), .clr_mask(bus_wdata[IRQ_N-1:0]),
    .pending(pending), .enable(enable), .source(source), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       engine_reset <= 1'b1;
    else if (wr_hold) engine_reset <= bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          sync_last <= '0;
    else if (sync_valid) sync_last <= sync_id;
  end

  ctl_read_mux #(
    .LVL_W(LVL_W), .DATA_W(DATA_W), .SYNC_W(SYNC_W),
    .VER_MINOR(VER_MINOR), .VER_PATCH(VER_PATCH)
  ) u_rmux (
    .addr(bus_addr), .hold(engine_reset), .enable(enable),
    .pending(pending), .source(source), .sync_last(sync_last),
    .cmd_room(cmd_room), .tx_room(tx_room), .rx_level(rx_level),
    .rx_valid(rx_valid), .rx_data(rx_data), .value(rd_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      bus_rvalid <= bus_ren;
      if (bus_ren) bus_rdata <= rd_value;
    end
  end

  assert_read_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ren |=> bus_rvalid);
  assert_sync_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_valid |=> (sync_last == $past(sync_id)));
  assert_hold_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hold && !bus_wdata[0]) |=> !engine_reset);
  assert_no_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> !rx_ready);
endmodule

// File: tb/sim_spi_cmd_ctl_regs.sv
module sim_spi_cmd_ctl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wen = 1'b0, bus_ren = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic        cmd_push_valid, tx_push_valid, rx_ready;
  logic        cmd_push_ready = 1'b1, tx_push_ready = 1'b1;
  logic [15:0] cmd_push_data;
  logic [7:0]  tx_push_data;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [5:0]  cmd_room = '0, tx_room = '0, rx_level = '0;
  logic        sync_valid = 1'b0;
  logic [7:0]  sync_id = '0;
  logic        engine_reset, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_cmd_ctl_regs u0 (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic popped);
    @(negedge clk);
    bus_ren = 1'b1; bus_addr = a;
    #1 popped = rx_ready;
    @(negedge clk);
    bus_ren = 1'b0;
    d = bus_rdata;
    check(bus_rvalid === 1'b1, "R12 rvalid after read", 32'(bus_rvalid), 1);
  endtask

  task automatic t_reset_state();
    logic [31:0] d; logic p;
    check(engine_reset === 1'b1, "R2 engine held after reset", 32'(engine_reset), 1);
    check(irq === 1'b0, "R5 irq low after reset", 32'(irq), 0);
    rd(8'h84, d, p); check(d === 32'h0, "R4 pending after reset", d, 0);
    rd(8'h80, d, p); check(d === 32'h0, "R3 enable after reset", d, 0);
    rd(8'h40, d, p); check(d === 32'h1, "R2 hold reads 1", d, 1);
  endtask

  task automatic t_ident();
    logic [31:0] d; logic p;
    rd(8'h00, d, p); check(d === 32'h0001_0261, "R1 identification word", d, 32'h0001_0261);
  endtask

  task automatic t_hold();
    logic [31:0] d; logic p;
    wr(8'h40, 32'h0);
    check(engine_reset === 1'b0, "R2 release", 32'(engine_reset), 0);
    rd(8'h40, d, p); check(d === 32'h0, "R2 hold reads 0", d, 0);
    wr(8'h40, 32'h1);
    check(engine_reset === 1'b1, "R2 hold again", 32'(engine_reset), 1);
    wr(8'h40, 32'h0);
  endtask

  task automatic t_enable();
    logic [31:0] d; logic p;
    wr(8'h80, 32'hFFFF_FFFF);
    rd(8'h80, d, p); check(d === 32'hF, "R3 enable masks to 4 bits", d, 32'hF);
    wr(8'h80, 32'h0);
    rd(8'h80, d, p); check(d === 32'h0, "R3 enable cleared", d, 0);
  endtask

  task automatic t_sync();
    logic [31:0] d; logic p;
    wr(8'h80, 32'hF);
    @(negedge clk); sync_valid = 1'b1; sync_id = 8'h5A;
    @(negedge clk); sync_valid = 1'b0; sync_id = 8'h00;
    check(irq === 1'b1, "R5 irq on sync", 32'(irq), 1);
    rd(8'hC0, d, p); check(d === 32'h5A, "R6 sync id", d, 32'h5A);
    rd(8'h84, d, p); check(d === 32'h8, "R6 sync pending", d, 32'h8);
    rd(8'h88, d, p); check(d === 32'h8, "R5 source", d, 32'h8);
    wr(8'h84, 32'h8);
    rd(8'h84, d, p); check(d === 32'h0, "R4 w1c sync", d, 0);
    check(irq === 1'b0, "R5 irq drops", 32'(irq), 0);
    wr(8'h80, 32'h0);
  endtask

  task automatic t_levels();
    logic [31:0] d; logic p;
    @(negedge clk); cmd_room = 6'd20;
    rd(8'h84, d, p); check(d === 32'h1, "R13 cmd low sets bit0", d, 1);
    wr(8'h84, 32'h1);
    rd(8'h84, d, p); check(d === 32'h1, "R13 clear ignored while active", d, 1);
    @(negedge clk); cmd_room = 6'd15;
    wr(8'h84, 32'h1);
    rd(8'h84, d, p); check(d === 32'h0, "R4 clear after condition ends", d, 0);
    @(negedge clk); tx_room = 6'd16; rx_level = 6'd30;
    rd(8'h84, d, p); check(d === 32'h6, "R13 tx at threshold and rx high", d, 32'h6);
    wr(8'h80, 32'h2);
    rd(8'h88, d, p); check(d === 32'h2, "R5 source masked", d, 32'h2);
    check(irq === 1'b1, "R5 irq masked cause", 32'(irq), 1);
    @(negedge clk); tx_room = 6'd15; rx_level = 6'd23;
    wr(8'h84, 32'hFF);
    rd(8'h84, d, p); check(d === 32'h0, "R4 clear all", d, 0);
    check(irq === 1'b0, "R5 irq cleared", 32'(irq), 0);
    wr(8'h80, 32'h0);
  endtask

  task automatic t_status();
    logic [31:0] d; logic p;
    @(negedge clk); cmd_room = 6'd9; tx_room = 6'd3; rx_level = 6'd17;
    rd(8'hD0, d, p); check(d === 32'd9, "R7 cmd room", d, 9);
    rd(8'hD4, d, p); check(d === 32'd3, "R7 tx room", d, 3);
    rd(8'hD8, d, p); check(d === 32'd17, "R7 rx level", d, 17);
    @(negedge clk); cmd_room = 0; tx_room = 0; rx_level = 0;
  endtask

  task automatic t_push();
    @(negedge clk);
    bus_wen = 1'b1; bus_addr = 8'hE0; bus_wdata = 32'hABCD_1234;
    #1;
    check(cmd_push_valid === 1'b1 && cmd_push_data === 16'h1234, "R8 cmd push",
          {15'h0, cmd_push_valid, cmd_push_data}, 32'h0001_1234);
    check(tx_push_valid === 1'b0, "R9 no tx push on cmd write", 32'(tx_push_valid), 0);
    @(negedge clk);
    bus_addr = 8'hE4; bus_wdata = 32'h0000_9C3E;
    #1;
    check(tx_push_valid === 1'b1 && tx_push_data === 8'h3E, "R9 tx push",
          {23'h0, tx_push_valid, tx_push_data}, 32'h0000_013E);
    check(cmd_push_valid === 1'b0, "R8 no cmd push on tx write", 32'(cmd_push_valid), 0);
    @(negedge clk); bus_wen = 1'b0;
  endtask

  task automatic t_rx();
    logic [31:0] d; logic p;
    @(negedge clk); rx_valid = 1'b1; rx_data = 8'h77;
    rd(8'hE8, d, p);
    check(d === 32'h77, "R10 pop data", d, 32'h77);
    check(p === 1'b1, "R10 pop strobe", 32'(p), 1);
    rd(8'hEC, d, p);
    check(d === 32'h77, "R11 peek data", d, 32'h77);
    check(p === 1'b0, "R11 peek no pop", 32'(p), 0);
    @(negedge clk); rx_valid = 1'b0;
    rd(8'hE8, d, p);
    check(d === 32'h0, "R10 empty pop returns 0", d, 0);
    check(p === 1'b0, "R10 empty no pop", 32'(p), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_ident();
    t_hold();
    t_enable();
    t_sync();
    t_levels();
    t_status();
    t_push();
    t_rx();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule